// File: doc/BRIEF.md
# Flash Program-Control and Security Register Block

This block sits on a small register bus and decides when on-chip program flash may be written or erased, and when a one-time security fuse may be burned. Firmware reaches three registers: a flash control register, a write-only fuse command register and a security register. The block drives a program-write-enable level that steers external-data stores into flash instead of data RAM, a mass-erase enable, a read-protect flag that cannot be cleared by software, and a burn pulse plus a burning level for the fuse logic.

The flash controller feeds back a pulse after each byte it programs and a pulse when a mass erase finishes; both clear the matching enable, so every store or erase needs a fresh arming by firmware. Program writes can only be armed while the global interrupt enable is low. A fuse burn needs a two-write key sequence and a separate permission bit in the security register, so a single stray store cannot blow a fuse. The external security pin is synchronised and shown in the security register.

The bus is single-cycle: a write takes effect at the clock edge where the write strobe is high, and read data is registered, appearing on the cycle after the read strobe.

Top module: `flash_guard_regs`

## Requirements
- R1: After reset, prog_wr_en, mass_erase_en, read_protect, fuse_go and fuse_burning are 0, and the control register (address 0) reads 0x00.
- R2: A write to the control register while irq_glob_en is 0 loads bit 0 into prog_wr_en; control register bit 0 reads back that value.
- R3: While irq_glob_en is 1, a control register write leaves prog_wr_en unchanged.
- R4: A flash_byte_done pulse clears prog_wr_en on the next edge; when a permitted control write arrives in the same cycle, the written bit 0 wins.
- R5: Control bit 1 loads mass_erase_en on every control write; an erase_done pulse clears it, and a control write in the same cycle wins.
- R6: Control bit 6 sets read_protect; writing 0 to it has no effect, and only reset clears it. It reads back in bit 6.
- R7: Writing 0x54 to the fuse register (address 1) and then 0xA6 as the next fuse write, while security bit 7 is 1, gives a one-cycle fuse_go pulse and sets fuse_burning.
- R8: A 0xA6 fuse write that is not directly preceded by a 0x54 fuse write, or that arrives while security bit 7 is 0, gives no fuse_go and leaves fuse_burning unchanged; any fuse write other than 0x54 clears the armed state.
- R9: Any fuse write of a value other than 0xA6 clears fuse_burning.
- R10: The security register (address 2) has read/write bit 7 (burn permission) and bits 1:0 (driven on sec_mode); bit 5 reads the sec_pin level after a two-flop synchroniser; bits 6, 4, 3, 2 read 0. The fuse register and unmapped addresses read 0x00.
- R11: bus_rdata is updated only on the cycle after bus_rd is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_glob_en | input | 1 | Global interrupt enable level |
| flash_byte_done | input | 1 | One-cycle pulse after a flash byte is programmed |
| erase_done | input | 1 | One-cycle pulse when a mass erase finishes |
| sec_pin | input | 1 | Security pin level, asynchronous |
| prog_wr_en | output | 1 | Steers external-data stores to flash |
| mass_erase_en | output | 1 | Mass erase permitted |
| read_protect | output | 1 | Sticky read protection |
| fuse_go | output | 1 | One-cycle fuse burn start pulse |
| fuse_burning | output | 1 | Fuse burn in progress |
| sec_mode | output | 2 | Security mode select bits |

## Verification
The two collisions that matter are a completion pulse from the flash controller landing in the same cycle as a firmware write to the control register, once for the byte-written pulse against bit 0 and once for the erase-done pulse against bit 1. The bench drives both strobes on the same falling edge and expects the written value to survive; it then sends the completion pulse alone and expects the enable to drop. A second overlap, a burn key written while a burn is already running, is judged by watching that no new pulse appears and that the burning level stays up.

// File: rtl/fgr_pkg.sv
package fgr_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // control register bit positions (firmware decodes these)
  localparam int unsigned CTL_PWE_BIT = 0;
  localparam int unsigned CTL_MEE_BIT = 1;
  localparam int unsigned CTL_RP_BIT  = 6;

  // security register bit positions
  localparam int unsigned SEC_EN_BIT  = 7;
  localparam int unsigned SEC_PIN_BIT = 5;
  localparam int unsigned SEC_MODE_W  = 2;
endpackage

// File: rtl/fgr_ctl.sv
module fgr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_pwe,
  input  logic w_mee,
  input  logic w_rp,
  input  logic irq_en,
  input  logic byte_done,
  input  logic erase_done,
  output logic pwe,
  output logic mee,
  output logic rp
);
  logic pwe_d, mee_d, rp_d;

  always_comb begin
    pwe_d = pwe;
    if (byte_done)     pwe_d = 1'b0;
    if (wr && !irq_en) pwe_d = w_pwe;
    mee_d = mee;
    if (erase_done)    mee_d = 1'b0;
    if (wr)            mee_d = w_mee;
    rp_d = rp | (wr & w_rp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwe <= 1'b0;
      mee <= 1'b0;
      rp  <= 1'b0;
    end else begin
      pwe <= pwe_d;
      mee <= mee_d;
      rp  <= rp_d;
    end
  end

  p_pwe_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && irq_en && !byte_done) |=> (pwe == $past(pwe)));
  p_pwe_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wr) |=> !pwe);
  p_mee_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_done && !wr) |=> !mee);
  p_rp_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rp |=> rp);
endmodule

// File: rtl/fgr_fuse.sv
module fgr_fuse #(
  parameter logic [7:0] ARM_KEY  = 8'h54,
  parameter logic [7:0] BURN_KEY = 8'hA6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       burn_ok,
  output logic       go,
  output logic       burning
);
  logic armed, armed_d, burning_d, go_d;

  always_comb begin
    armed_d   = armed;
    burning_d = burning;
    go_d      = 1'b0;
    if (wr) begin
      armed_d = (wdata == ARM_KEY);
      if (wdata == BURN_KEY) begin
        if (armed && burn_ok) begin
          go_d      = 1'b1;
          burning_d = 1'b1;
        end
      end else begin
        burning_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      burning <= 1'b0;
      go      <= 1'b0;
    end else begin
      armed   <= armed_d;
      burning <= burning_d;
      go      <= go_d;
    end
  end

  p_go_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  p_go_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == BURN_KEY && !burn_ok) |=> !go);
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata != BURN_KEY) |=> !burning);
endmodule

// File: rtl/fgr_sec.sv
module fgr_sec #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              w_en,
  input  logic [MODE_W-1:0] w_mode,
  input  logic              pin,
  output logic              burn_en,
  output logic              pin_sync,
  output logic [MODE_W-1:0] mode
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   en_d;
  logic [MODE_W-1:0]      mode_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = pin;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign pin_sync = sync_q[SYNC_STAGES-1];

  always_comb begin
    en_d   = burn_en;
    mode_d = mode;
    if (wr) begin
      en_d   = w_en;
      mode_d = w_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      burn_en <= 1'b0;
      mode    <= '0;
    end else begin
      sync_q  <= sync_d;
      burn_en <= en_d;
      mode    <= mode_d;
    end
  end

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mode));
endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import fgr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [3:0]  CTL_ADDR  = 4'd0,
  parameter logic [3:0]  FUSE_ADDR = 4'd1,
  parameter logic [3:0]  SEC_ADDR  = 4'd2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              irq_glob_en,
  input  logic              flash_byte_done,
  input  logic              erase_done,
  input  logic              sec_pin,
  output logic              prog_wr_en,
  output logic              mass_erase_en,
  output logic              read_protect,
  output logic              fuse_go,
  output logic              fuse_burning,
  output logic [1:0]        sec_mode
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       wr_ctl, wr_fuse, wr_sec;
  logic       burn_en, pin_sync;
  byte_t      rd_mux, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_ctl  = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
  assign wr_fuse = bus_wr && (bus_addr == ADDR_W'(FUSE_ADDR));
  assign wr_sec  = bus_wr && (bus_addr == ADDR_W'(SEC_ADDR));

  fgr_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (wr_ctl),
    .w_pwe      (bus_wdata[CTL_PWE_BIT]),
    .w_mee      (bus_wdata[CTL_MEE_BIT]),
    .w_rp       (bus_wdata[CTL_RP_BIT]),
    .irq_en     (irq_glob_en),
    .byte_done  (flash_byte_done),
    .erase_done (erase_done),
    .pwe        (prog_wr_en),
    .mee        (mass_erase_en),
    .rp         (read_protect)
  );

  fgr_fuse u_fuse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (wr_fuse),
    .wdata   (bus_wdata),
    .burn_ok (burn_en),
    .go      (fuse_go),
    .burning (fuse_burning)
  );

  fgr_sec #(.SYNC_STAGES(SYNC_STAGES), .MODE_W(SEC_MODE_W)) u_sec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (wr_sec),
    .w_en     (bus_wdata[SEC_EN_BIT]),
    .w_mode   (bus_wdata[SEC_MODE_W-1:0]),
    .pin      (sec_pin),
    .burn_en  (burn_en),
    .pin_sync (pin_sync),
    .mode     (sec_mode)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(CTL_ADDR)) begin
      rd_mux[CTL_PWE_BIT] = prog_wr_en;
      rd_mux[CTL_MEE_BIT] = mass_erase_en;
      rd_mux[CTL_RP_BIT]  = read_protect;
    end else if (bus_addr == ADDR_W'(SEC_ADDR)) begin
      rd_mux[SEC_EN_BIT]         = burn_en;
      rd_mux[SEC_PIN_BIT]        = pin_sync;
      rd_mux[SEC_MODE_W-1:0]     = sec_mode;
    end
    rdata_d = bus_rd ? rd_mux : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else             bus_rdata <= rdata_d;
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_flash_guard_regs.sv
module sim_flash_guard_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_rdata;
  logic       irq_glob_en, flash_byte_done, erase_done, sec_pin;
  logic       prog_wr_en, mass_erase_en, read_protect, fuse_go, fuse_burning;
  logic [1:0] sec_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rd_seen = 1'b0;
  logic go_seen;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #4 clk = ~clk;

  flash_guard_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_glob_en(irq_glob_en), .flash_byte_done(flash_byte_done),
    .erase_done(erase_done), .sec_pin(sec_pin), .prog_wr_en(prog_wr_en),
    .mass_erase_en(mass_erase_en), .read_protect(read_protect),
    .fuse_go(fuse_go), .fuse_burning(fuse_burning), .sec_mode(sec_mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // driver tasks: inputs change on the falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d,
                        input logic bd = 1'b0, input logic ed = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    flash_byte_done = bd; erase_done = ed;
    @(negedge clk);
    go_seen = fuse_go;
    bus_wr = 1'b0; flash_byte_done = 1'b0; erase_done = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic bd, input logic ed);
    @(negedge clk);
    flash_byte_done = bd; erase_done = ed;
    @(negedge clk);
    flash_byte_done = 1'b0; erase_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    irq_glob_en = 1'b0; flash_byte_done = 1'b0; erase_done = 1'b0; sec_pin = 1'b0;
    go_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", {3'b0, prog_wr_en, mass_erase_en, read_protect, fuse_go, fuse_burning}, 8'h00);
    rd_reg(4'd0, 8'h00, "R1");

    // R2 arm program write with interrupts off
    wr_reg(4'd0, 8'h01);
    check("R2", {7'b0, prog_wr_en}, 8'h01);
    rd_reg(4'd0, 8'h01, "R2");

    // R3 write ignored with interrupts on
    irq_glob_en = 1'b1;
    wr_reg(4'd0, 8'h00);
    check("R3", {7'b0, prog_wr_en}, 8'h01);
    rd_reg(4'd0, 8'h01, "R3");
    irq_glob_en = 1'b0;

    // R4 self clear, then collision with a write
    pulse(1'b1, 1'b0);
    check("R4", {7'b0, prog_wr_en}, 8'h00);
    wr_reg(4'd0, 8'h01, 1'b1, 1'b0);
    check("R4 same-cycle", {7'b0, prog_wr_en}, 8'h01);
    pulse(1'b1, 1'b0);
    check("R4", {7'b0, prog_wr_en}, 8'h00);

    // R5 mass erase enable
    wr_reg(4'd0, 8'h02);
    check("R5", {7'b0, mass_erase_en}, 8'h01);
    rd_reg(4'd0, 8'h02, "R5");
    pulse(1'b0, 1'b1);
    check("R5", {7'b0, mass_erase_en}, 8'h00);
    wr_reg(4'd0, 8'h02, 1'b0, 1'b1);
    check("R5 same-cycle", {7'b0, mass_erase_en}, 8'h01);
    pulse(1'b0, 1'b1);
    check("R5", {7'b0, mass_erase_en}, 8'h00);

    // R6 read protect set-only
    wr_reg(4'd0, 8'h40);
    check("R6", {7'b0, read_protect}, 8'h01);
    wr_reg(4'd0, 8'h00);
    check("R6", {7'b0, read_protect}, 8'h01);
    rd_reg(4'd0, 8'h40, "R6");

    // R8 burn key without permission or without arming
    wr_reg(4'd1, 8'hA6);
    check("R8 unarmed", {6'b0, go_seen, fuse_burning}, 8'h00);
    wr_reg(4'd1, 8'h54);
    wr_reg(4'd1, 8'hA6);
    check("R8 no-perm", {6'b0, go_seen, fuse_burning}, 8'h00);

    // R10 security register
    wr_reg(4'd2, 8'h83);
    check("R10 mode", {6'b0, sec_mode}, 8'h03);
    rd_reg(4'd2, 8'h83, "R10");
    sec_pin = 1'b1;
    repeat (3) @(negedge clk);
    wr_reg(4'd2, 8'hFF);
    rd_reg(4'd2, 8'hA3, "R10 pin");
    rd_reg(4'd1, 8'h00, "R10 fuse-wo");
    rd_reg(4'd3, 8'h00, "R10 unmapped");

    // R7 armed burn with permission
    wr_reg(4'd1, 8'h54);
    wr_reg(4'd1, 8'hA6);
    check("R7 go", {6'b0, go_seen, fuse_burning}, 8'h03);
    @(negedge clk);
    check("R7 pulse-end", {7'b0, fuse_go}, 8'h00);
    // R8 repeated key while burning: no new pulse, still burning
    wr_reg(4'd1, 8'hA6);
    check("R8 repeat", {6'b0, go_seen, fuse_burning}, 8'h01);

    // R9 stop
    wr_reg(4'd1, 8'h00);
    check("R9", {7'b0, fuse_burning}, 8'h00);

    // R8 arm cleared by another value
    wr_reg(4'd1, 8'h54);
    wr_reg(4'd1, 8'h12);
    wr_reg(4'd1, 8'hA6);
    check("R8 disarmed", {6'b0, go_seen, fuse_burning}, 8'h00);

    // R11 read data holds without a read strobe
    rd_reg(4'd0, 8'h40, "R11");
    wr_reg(4'd0, 8'h03);
    repeat (2) @(negedge clk);
    check("R11 hold", bus_rdata, 8'h40);
    rd_reg(4'd0, 8'h43, "R11");

    repeat (3) @(negedge clk);
    check("queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule